// File: doc/BRIEF.md
# Dual Decade Counter with Edge-Qualified Count Inputs

The block holds two identical and fully independent decimal counters, named channel A and channel B. Each counter keeps one BCD digit. It steps 0, 1, ..., 9 and then wraps to 0. Each channel has two count-request inputs:

- An "up-edge" input, which counts on its rising edge.
- A "down-edge" input, which counts on its falling edge.

Each input qualifies the other. Holding the down-edge input high makes the up-edge input a rising-edge count clock. Holding the up-edge input low makes the down-edge input a falling-edge count clock. In both cases the idle input works as a count enable.

Everything runs on one system clock. Each request input passes through a two-flop synchronizer. An edge is found by comparing each synchronized sample with the sample before it. Each channel also has an active-high clear input. The clear forces the digit to zero asynchronously. Its release is synchronized to the system clock.

Top module: `dual_decade_counter`

## Requirements
- R1: While a channel's clear input is high, its digit output reads 0 within the same clock cycle, whatever its request inputs do.
- R2: A rising edge on the up-edge input advances the digit by one when the down-edge input was high in the sample before that edge.
- R3: A falling edge on the down-edge input advances the digit by one when the up-edge input was low in the sample before that edge.
- R4: These edges leave the digit unchanged:
  - a rising up-edge input while the down-edge input was low;
  - a falling down-edge input while the up-edge input was high;
  - any falling edge of the up-edge input;
  - any rising edge of the down-edge input.
- R5: An advance from 9 gives 0. All other advances give the current value plus one.
- R6: When a qualified up-edge rise and a qualified down-edge fall occur in the same sample, the digit advances by exactly one.
- R7: Releasing clear never causes an advance, whatever the input levels are at release. Counting resumes on the second clock edge after clear falls.
- R8: Channels A and B share only the system clock. Stimulus or clear on one channel never changes the other channel's digit.
- R9: The digit output is always a legal BCD value, 0 to 9. Bit 0 is the least significant bit.
- R10: An input change that causes an advance first shows on the digit output at the third rising clock edge after the change. The output before that edge still holds the old value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| a_clear | input | 1 | Channel A asynchronous clear, active high |
| a_up_edge | input | 1 | Channel A rising-edge count request |
| a_dn_edge | input | 1 | Channel A falling-edge count request |
| a_digit | output | 4 | Channel A BCD digit |
| b_clear | input | 1 | Channel B asynchronous clear, active high |
| b_up_edge | input | 1 | Channel B rising-edge count request |
| b_dn_edge | input | 1 | Channel B falling-edge count request |
| b_digit | output | 4 | Channel B BCD digit |

## Verification
A wrong edge history or qualifier shows up as one extra or one missing step in the digit. It appears three clock edges after the input change that caused it. A reference count checks each step against the digit at exactly that edge, and checks just before it that the old value still holds. A stale history at clear release would show as a nonzero digit within a few cycles after clear falls. A corrupted count register would show as a value above 9, or as a wrong wrap, at the first advance from 9.

// File: rtl/ddc_pkg.sv
package ddc_pkg;
  localparam int unsigned DIGIT_W   = 4;
  localparam int unsigned DIGIT_MAX = 9;
  typedef logic [DIGIT_W-1:0] digit_t;

  function automatic digit_t next_digit(input digit_t d);
    if (d >= digit_t'(DIGIT_MAX)) return '0;
    return d + digit_t'(1);
  endfunction
endpackage

// File: rtl/ddc_sync.sv
module ddc_sync #(
  parameter int unsigned STAGES = 2,
  parameter int unsigned WIDTH  = 2
) (
  input  logic             clk,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  logic [WIDTH-1:0] pipe [STAGES];

  always_ff @(posedge clk) begin
    pipe[0] <= din;
    for (int i = 1; i < int'(STAGES); i++) pipe[i] <= pipe[i-1];
  end

  assign dout = pipe[STAGES-1];
endmodule

// File: rtl/ddc_rst_sync.sv
module ddc_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic clear,
  output logic hold
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or posedge clear) begin
    if (clear) chain <= '1;
    else       chain <= {chain[STAGES-2:0], 1'b0};
  end

  assign hold = chain[STAGES-1];
endmodule

// File: rtl/ddc_edge_qual.sv
module ddc_edge_qual (
  input  logic clk,
  input  logic hold,
  input  logic up_s,
  input  logic dn_s,
  output logic adv
);
  logic up_p, dn_p;
  logic up_rise_ok, dn_fall_ok;

  // history follows the samples even in hold, so release shows no edge
  always_ff @(posedge clk) begin
    up_p <= up_s;
    dn_p <= dn_s;
  end

  assign up_rise_ok = up_s & ~up_p & dn_p;
  assign dn_fall_ok = dn_p & ~dn_s & ~up_p;
  assign adv        = ~hold & (up_rise_ok | dn_fall_ok);

  // R4
  upfall_no_adv_chk: assert property (@(posedge clk) disable iff (hold)
    (up_p & ~up_s) && !(dn_p & ~dn_s & ~up_p) |-> !adv);
  // R7
  hold_no_adv_chk: assert property (@(posedge clk) hold |-> !adv);
endmodule

// File: rtl/ddc_digit.sv
module ddc_digit
  import ddc_pkg::*;
(
  input  logic   clk,
  input  logic   hold,
  input  logic   adv,
  output digit_t count
);
  always_ff @(posedge clk or posedge hold) begin
    if (hold)     count <= '0;
    else if (adv) count <= next_digit(count);
  end

  // R9
  digit_legal_chk: assert property (@(posedge clk) disable iff (hold)
    count <= digit_t'(DIGIT_MAX));
  // R5
  step_value_chk: assert property (@(posedge clk) disable iff (hold)
    adv |=> count == next_digit($past(count)));
  // R4
  idle_stable_chk: assert property (@(posedge clk) disable iff (hold)
    !adv |=> $stable(count));
endmodule

// File: rtl/ddc_channel.sv
module ddc_channel
  import ddc_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned RST_STAGES  = 2
) (
  input  logic   clk,
  input  logic   clear,
  input  logic   up_edge,
  input  logic   dn_edge,
  output digit_t digit
);
  logic       hold, adv;
  logic [1:0] req_s;

  ddc_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk(clk), .clear(clear), .hold(hold));

  ddc_sync #(.STAGES(SYNC_STAGES), .WIDTH(2)) u_sync (
    .clk(clk), .din({dn_edge, up_edge}), .dout(req_s));

  ddc_edge_qual u_qual (
    .clk(clk), .hold(hold), .up_s(req_s[0]), .dn_s(req_s[1]), .adv(adv));

  ddc_digit u_digit (
    .clk(clk), .hold(hold), .adv(adv), .count(digit));

  // R1
  clear_zero_chk: assert property (@(posedge clk) clear |-> digit == '0);
endmodule

// File: rtl/dual_decade_counter.sv
module dual_decade_counter
  import ddc_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned RST_STAGES  = 2
) (
  input  logic               clk,
  input  logic               a_clear,
  input  logic               a_up_edge,
  input  logic               a_dn_edge,
  output logic [DIGIT_W-1:0] a_digit,
  input  logic               b_clear,
  input  logic               b_up_edge,
  input  logic               b_dn_edge,
  output logic [DIGIT_W-1:0] b_digit
);
  localparam int unsigned NCH = 2;

  logic   ch_clear [NCH];
  logic   ch_up    [NCH];
  logic   ch_dn    [NCH];
  digit_t ch_digit [NCH];

  assign ch_clear[0] = a_clear;
  assign ch_up[0]    = a_up_edge;
  assign ch_dn[0]    = a_dn_edge;
  assign ch_clear[1] = b_clear;
  assign ch_up[1]    = b_up_edge;
  assign ch_dn[1]    = b_dn_edge;

  // R8: channels share nothing but clk
  for (genvar g = 0; g < int'(NCH); g++) begin : g_ch
    ddc_channel #(.SYNC_STAGES(SYNC_STAGES), .RST_STAGES(RST_STAGES)) u_ch (
      .clk(clk), .clear(ch_clear[g]), .up_edge(ch_up[g]),
      .dn_edge(ch_dn[g]), .digit(ch_digit[g]));
  end

  assign a_digit = ch_digit[0];
  assign b_digit = ch_digit[1];
endmodule

// File: tb/dual_decade_counter_test.sv
module dual_decade_counter_test;
  logic clk = 1'b0;
  logic a_clear = 1'b1, a_up = 1'b0, a_dn = 1'b0;
  logic b_clear = 1'b1, b_up = 1'b0, b_dn = 1'b0;
  logic [3:0] a_digit, b_digit;

  int n_tests = 0, n_fail = 0;
  logic [3:0] ea = 0, eb = 0;
  logic pua = 0, pda = 0, pub = 0, pdb = 0;

  always #2.5 clk = ~clk;

  dual_decade_counter uut (
    .clk(clk), .a_clear(a_clear), .a_up_edge(a_up), .a_dn_edge(a_dn),
    .a_digit(a_digit), .b_clear(b_clear), .b_up_edge(b_up),
    .b_dn_edge(b_dn), .b_digit(b_digit));

  function automatic logic qual(logic pu, logic pd, logic nu, logic nd);
    return (!pu && nu && pd) || (pd && !nd && !pu);
  endfunction

  function automatic logic [3:0] bump(logic [3:0] d);
    return (d == 4'd9) ? 4'd0 : d + 4'd1;
  endfunction

  task automatic chk(string req, logic [3:0] act, logic [3:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // drive both channels, check hold-off (R10) and result
  task automatic step(string req, logic nua, logic nda, logic nub, logic ndb);
    logic [3:0] oa, ob;
    oa = ea; ob = eb;
    @(negedge clk);
    if (qual(pua, pda, nua, nda)) ea = bump(ea);
    if (qual(pub, pdb, nub, ndb)) eb = bump(eb);
    pua = nua; pda = nda; pub = nub; pdb = ndb;
    a_up = nua; a_dn = nda; b_up = nub; b_dn = ndb;
    @(posedge clk); @(posedge clk);
    @(negedge clk);
    chk("R10 a", a_digit, oa);
    chk("R10 b", b_digit, ob);
    @(posedge clk);
    @(negedge clk);
    chk({req, " a"}, a_digit, ea);
    chk({req, " b"}, b_digit, eb);
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd4518));
    #1;
    chk("R1 reset a", a_digit, 0);
    chk("R1 reset b", b_digit, 0);
    idle(4);
    @(negedge clk); a_clear = 0; b_clear = 0;
    idle(4);
    chk("R7 release a", a_digit, 0);
    // R2: dn high enables up rising
    step("R4 dn rise", 0, 1, 0, 0);
    step("R2 up rise", 1, 1, 0, 0);
    step("R4 up fall", 0, 1, 0, 0);
    step("R2 up rise", 1, 1, 0, 0);
    chk("R2 count", a_digit, 2);
    chk("R8 b idle", b_digit, 0);
    // R4 non-qualifying edges
    step("R4 dn fall up high", 1, 0, 0, 0);
    step("R4 up fall", 0, 0, 0, 0);
    step("R4 up rise dn low", 1, 0, 0, 0);
    chk("R4 count", a_digit, 2);
    // R3: up low enables dn falling
    step("R4 setup", 0, 0, 0, 1);
    step("R4 dn rise", 0, 1, 0, 1);
    step("R3 dn fall", 0, 0, 0, 0);
    chk("R3 count", a_digit, 3);
    chk("R3 b count", b_digit, 1);
    // R6: both qualify in one sample
    step("R6 setup", 0, 1, 0, 1);
    step("R6 both", 1, 0, 1, 0);
    chk("R6 count", a_digit, 4);
    // R5 wrap
    step("R5 setup", 0, 1, 0, 0);
    for (int i = 0; i < 7; i++) begin
      step("R5 climb", 1, 1, 0, 0);
      step("R5 climb", 0, 1, 0, 0);
    end
    chk("R5 wrap", a_digit, 1);
    // R1/R7: clear mid-count, inputs toggling, release with up and dn high
    @(negedge clk); a_clear = 1; #1;
    chk("R1 async clear", a_digit, 0);
    chk("R8 b kept", b_digit, eb);
    ea = 0;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk); a_up = ~a_up; a_dn = ~a_dn;
      chk("R1 held", a_digit, 0);
    end
    @(negedge clk); a_up = 1; a_dn = 1; pua = 1; pda = 1;
    idle(4);
    @(negedge clk); a_clear = 0;
    idle(6);
    chk("R7 no false step", a_digit, 0);
    step("R7 resume", 0, 1, pub, pdb);
    step("R7 resume", 1, 1, pub, pdb);
    chk("R7 counts", a_digit, 1);
    // R8 random, independent channels
    for (int i = 0; i < 400; i++) begin
      logic [3:0] r;
      r = 4'($urandom);
      step("R8 random", r[0], r[1], r[2], r[3]);
    end
    // R1 clear on B only
    @(negedge clk); b_clear = 1; #1;
    chk("R1 b clear", b_digit, 0);
    chk("R8 a kept", a_digit, ea);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule